// File: doc/BRIEF.md
# Low-Power Mode Controller

This block tracks the power state of a small microcontroller core and turns that state into clock and reset controls. A strobe from the CPU's sleep instruction picks one of two halted states, depending on a standby-select bit. In light sleep only the CPU clock stops. In deep standby the oscillator stops as well. An active-low hardware standby pin overrides everything else. It halts all clocks and holds the peripherals in reset, and it is left only through a timed reset sequence.

While the core runs, a medium-speed enable slows the CPU and the other bus masters. It does this by issuing one CPU clock-enable pulse per divided period. The period is 2 to 32 input clocks. A per-module stop mask gates peripheral clocks one by one and never touches the CPU. A 3-bit status output reports the current mode.

Inputs are sampled on the rising edge of `clk`. The hardware standby pin must be synchronised to `clk` before it reaches this block.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode output reads 0 (active), `cpu_clk_en` and `osc_en` are 1, `periph_rst` is 0, `div_ratio` is 0 and `mod_clk_en` equals the inverse of `mod_stop`.
- R2: A `sleep_req` while running (mode 0 or 1) with `stby_sel` = 0 gives mode 2 (sleep) from the next cycle. In sleep `cpu_clk_en` is 0 and `osc_en` stays 1.
- R3: In sleep, `irq_req` or `wake_req` returns the block to mode 0 on the next cycle, with `cpu_clk_en` at 1.
- R4: A `sleep_req` while running with `stby_sel` = 1 gives mode 3 (software standby) from the next cycle. In this state `cpu_clk_en`, `osc_en` and every `mod_clk_en` bit are 0, and `irq_req` has no effect.
- R5: In software standby, `wake_req` sets `osc_en` to 1 on the next cycle. The mode stays 3 and `cpu_clk_en` stays 0 for SETTLE_CYC cycles, after which the mode is 0 with `cpu_clk_en` at 1.
- R6: While `hw_stby_n` is 0, the next cycle shows mode 4 (hardware standby) whatever the state and the other inputs. In this mode `periph_rst` is 1 and `osc_en`, `cpu_clk_en` and all `mod_clk_en` bits are 0.
- R7: When `hw_stby_n` returns to 1, the next cycle shows `osc_en` at 1. `periph_rst` stays 1, the mode stays 4 and `cpu_clk_en` stays 0 for RST_CYC cycles, after which the mode is 0 and `periph_rst` is 0. `periph_rst` is never 1 in any other mode.
- R8: When `med_en` is 1 in the active state, the mode is 1 from the next cycle. `cpu_clk_en` is then high for one cycle in every 2^(code+1) cycles, starting with the first medium-speed cycle. `div_sel` codes 0 to 4 give ratios 2, 4, 8, 16 and 32, and codes 5 to 7 act as code 4. `div_ratio` shows the code in use, and it is 0 outside mode 1.
- R9: A change of `div_sel` in medium speed leaves the running period at its old length. The new ratio, and the new `div_ratio` value, start on the cycle of the next `cpu_clk_en` pulse.
- R10: In modes 0, 1 and 2, `mod_clk_en[i]` equals the inverse of `mod_stop[i]`. The mask never changes `cpu_clk_en`.
- R11: Clearing `med_en` in medium speed returns the block to mode 0 on the next cycle, with `cpu_clk_en` at 1 and `div_ratio` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| stby_sel | input | 1 | 0 selects sleep, 1 selects software standby |
| hw_stby_n | input | 1 | Hardware standby pin, active low, already synchronised |
| med_en | input | 1 | Medium-speed enable |
| div_sel | input | 3 | Medium-speed ratio code |
| mod_stop | input | N_MOD | Per-module clock stop mask |
| irq_req | input | 1 | Interrupt request, ends sleep |
| wake_req | input | 1 | External wake request, ends sleep or software standby |
| cpu_clk_en | output | 1 | CPU and bus-master clock enable |
| osc_en | output | 1 | Main oscillator enable |
| periph_rst | output | 1 | Peripheral module reset |
| mod_clk_en | output | N_MOD | Per-module clock enables |
| div_ratio | output | 3 | Ratio code in use (0 outside medium speed) |
| mode | output | 3 | 0 active, 1 medium, 2 sleep, 3 software standby, 4 hardware standby |

## Verification
The bench changes `div_sel` in the middle of a divided period. A design that reloads the ratio at once would emit the next pulse early, or emit one late and shortened. It counts the settling and reset-recovery windows cycle by cycle, so a timer that is off by one shows up as an early or a late `cpu_clk_en`. It pulls the hardware standby pin low while sleep, interrupt and wake inputs are also active. A design that ranks the pin below them would fail to enter mode 4, or would leave it early. It also checks that interrupts are ignored in software standby and that out-of-range ratio codes clamp to 32.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    S_ACT, S_MED, S_SLP, S_SSB, S_SET, S_HSB, S_REC
  } lpm_st_e;

  localparam logic [2:0] MODE_ACT = 3'd0;
  localparam logic [2:0] MODE_MED = 3'd1;
  localparam logic [2:0] MODE_SLP = 3'd2;
  localparam logic [2:0] MODE_SSB = 3'd3;
  localparam logic [2:0] MODE_HSB = 3'd4;

  // Map internal state to the reported mode code.
  function automatic logic [2:0] mode_of(lpm_st_e s);
    case (s)
      S_ACT:        return MODE_ACT;
      S_MED:        return MODE_MED;
      S_SLP:        return MODE_SLP;
      S_SSB, S_SET: return MODE_SSB;
      default:      return MODE_HSB;
    endcase
  endfunction

  // Clamp a ratio code to the largest supported one.
  function automatic logic [2:0] clamp_code(logic [2:0] sel, logic [2:0] max_code);
    return (sel > max_code) ? max_code : sel;
  endfunction

  // Length of one divided period, in input clocks, minus one.
  function automatic logic [5:0] last_count(logic [2:0] code);
    return 6'((7'd2 << code) - 7'd1);
  endfunction

endpackage

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned RST_CYC    = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_req,
  input  logic    stby_sel,
  input  logic    hw_stby_n,
  input  logic    med_en,
  input  logic    irq_req,
  input  logic    wake_req,
  output lpm_st_e st
);
  localparam int unsigned TMAX  = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int unsigned TMR_W = $clog2(TMAX + 1);

  logic [TMR_W-1:0] tmr;
  logic             settle_done;
  logic             recov_done;
  lpm_st_e          halt_st;

  assign settle_done = (tmr == TMR_W'(SETTLE_CYC - 1));
  assign recov_done  = (tmr == TMR_W'(RST_CYC - 1));
  assign halt_st     = stby_sel ? S_SSB : S_SLP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_ACT;
      tmr <= '0;
    end else if (!hw_stby_n) begin
      st  <= S_HSB;
      tmr <= '0;
    end else begin
      case (st)
        S_ACT: begin
          if (sleep_req)   st <= halt_st;
          else if (med_en) st <= S_MED;
        end
        S_MED: begin
          if (sleep_req)    st <= halt_st;
          else if (!med_en) st <= S_ACT;
        end
        S_SLP: if (irq_req || wake_req) st <= S_ACT;
        S_SSB: if (wake_req) begin
          st  <= S_SET;
          tmr <= '0;
        end
        S_SET: begin
          if (settle_done) st <= S_ACT;
          else             tmr <= tmr + 1'b1;
        end
        S_HSB: begin
          st  <= S_REC;
          tmr <= '0;
        end
        S_REC: begin
          if (recov_done) st <= S_ACT;
          else            tmr <= tmr + 1'b1;
        end
        default: st <= S_ACT;
      endcase
    end
  end
endmodule

// File: rtl/lpm_div.sv
module lpm_div
  import lpm_pkg::*;
#(
  parameter int unsigned MAX_CODE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_med,
  input  logic [2:0] div_sel,
  output logic       div_tick,
  output logic       div_wrap,
  output logic [2:0] code
);
  localparam int unsigned CNT_W = MAX_CODE + 1;
  localparam logic [2:0]  MAXC  = 3'(MAX_CODE);

  logic [CNT_W-1:0] cnt;

  assign div_tick = (cnt == '0);
  assign div_wrap = in_med && (6'(cnt) == last_count(code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      code <= '0;
    end else if (!in_med || div_wrap) begin
      cnt  <= '0;
      code <= clamp_code(div_sel, MAXC);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
#(
  parameter int unsigned N_MOD = 8
) (
  input  lpm_st_e          st,
  input  logic             div_tick,
  input  logic [2:0]       code,
  input  logic [N_MOD-1:0] mod_stop,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             periph_rst,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [2:0]       div_ratio,
  output logic [2:0]       mode
);
  logic mods_run;

  assign mods_run   = (st == S_ACT) || (st == S_MED) || (st == S_SLP);
  assign cpu_clk_en = (st == S_ACT) || ((st == S_MED) && div_tick);
  assign osc_en     = !((st == S_SSB) || (st == S_HSB));
  assign periph_rst = (st == S_HSB) || (st == S_REC);
  assign div_ratio  = (st == S_MED) ? code : 3'd0;
  assign mode       = mode_of(st);

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    assign mod_clk_en[i] = mods_run && !mod_stop[i];
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned N_MOD      = 8,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned RST_CYC    = 8,
  parameter int unsigned MAX_CODE   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             stby_sel,
  input  logic             hw_stby_n,
  input  logic             med_en,
  input  logic [2:0]       div_sel,
  input  logic [N_MOD-1:0] mod_stop,
  input  logic             irq_req,
  input  logic             wake_req,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             periph_rst,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [2:0]       div_ratio,
  output logic [2:0]       mode
);
  lpm_st_e    st;
  logic       in_med;
  logic       div_tick;
  logic       div_wrap;
  logic [2:0] code;

  assign in_med = (st == S_MED);

  lpm_seq #(.SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
    .hw_stby_n(hw_stby_n), .med_en(med_en), .irq_req(irq_req),
    .wake_req(wake_req), .st(st)
  );

  lpm_div #(.MAX_CODE(MAX_CODE)) u_div (
    .clk(clk), .rst_n(rst_n), .in_med(in_med), .div_sel(div_sel),
    .div_tick(div_tick), .div_wrap(div_wrap), .code(code)
  );

  lpm_gate #(.N_MOD(N_MOD)) u_gate (
    .st(st), .div_tick(div_tick), .code(code), .mod_stop(mod_stop),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .periph_rst(periph_rst),
    .mod_clk_en(mod_clk_en), .div_ratio(div_ratio), .mode(mode)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int unsigned N_MOD      = 8,
  parameter int unsigned SETTLE_CYC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             stby_sel,
  input logic             hw_stby_n,
  input logic [N_MOD-1:0] mod_stop,
  input logic             cpu_clk_en,
  input logic             osc_en,
  input logic             periph_rst,
  input logic [N_MOD-1:0] mod_clk_en,
  input logic [2:0]       div_ratio,
  input logic [2:0]       mode,
  input logic             div_wrap
);
  logic [31:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    settle_cnt <= '0;
    else if (mode == 3'd3 && osc_en) settle_cnt <= settle_cnt + 1;
    else                           settle_cnt <= '0;
  end

  // R2
  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 3'd1 && sleep_req && !stby_sel && hw_stby_n) |=> (mode == 3'd2 && !cpu_clk_en && osc_en));

  // R4
  p_swstby_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !osc_en) |-> (!cpu_clk_en && mod_clk_en == '0));

  // R5
  p_settle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && osc_en) |-> (!cpu_clk_en && settle_cnt < SETTLE_CYC));

  // R6
  p_hw_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_stby_n |=> (mode == 3'd4 && periph_rst && !osc_en && !cpu_clk_en));

  // R7
  p_rst_only_hw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> (mode == 3'd4 && !cpu_clk_en));

  // R8
  p_med_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && cpu_clk_en && !div_wrap) |=> (mode != 3'd1 || !cpu_clk_en));

  // R9
  p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !div_wrap) |=> (mode != 3'd1 || $stable(div_ratio)));

  // R10
  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 3'd2) |-> (mod_clk_en == ~mod_stop));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_MOD(N_MOD), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
  .hw_stby_n(hw_stby_n), .mod_stop(mod_stop), .cpu_clk_en(cpu_clk_en),
  .osc_en(osc_en), .periph_rst(periph_rst), .mod_clk_en(mod_clk_en),
  .div_ratio(div_ratio), .mode(mode), .div_wrap(div_wrap)
);

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_MOD      = 8;
  localparam int unsigned SETTLE_CYC = 16;
  localparam int unsigned RST_CYC    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, stby_sel = 1'b0, hw_stby_n = 1'b1, med_en = 1'b0;
  logic irq_req = 1'b0, wake_req = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [N_MOD-1:0] mod_stop = 8'hA5;
  logic cpu_clk_en, osc_en, periph_rst;
  logic [N_MOD-1:0] mod_clk_en;
  logic [2:0] div_ratio, mode;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpm_ctrl #(.N_MOD(N_MOD), .SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
    .hw_stby_n(hw_stby_n), .med_en(med_en), .div_sel(div_sel),
    .mod_stop(mod_stop), .irq_req(irq_req), .wake_req(wake_req),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .periph_rst(periph_rst),
    .mod_clk_en(mod_clk_en), .div_ratio(div_ratio), .mode(mode)
  );

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) nx();
    rst_n = 1'b1;
    nx();
    check("R1", "mode", mode, 0);
    check("R1", "cpu/osc/rst", {cpu_clk_en, osc_en, periph_rst}, 3'b110);
    check("R1", "div_ratio", div_ratio, 0);
    check("R1", "mod_clk_en", mod_clk_en, 8'h5A);
  endtask

  task automatic t_sleep();
    stby_sel = 1'b0; sleep_req = 1'b1;
    nx();
    sleep_req = 1'b0;
    check("R2", "mode", mode, 2);
    check("R2", "cpu/osc", {cpu_clk_en, osc_en}, 2'b01);
    check("R10", "mod in sleep", mod_clk_en, 8'h5A);
    nx();
    check("R2", "mode held", mode, 2);
    irq_req = 1'b1;
    nx();
    irq_req = 1'b0;
    check("R3", "mode after irq", mode, 0);
    check("R3", "cpu after irq", cpu_clk_en, 1);
  endtask

  task automatic t_swstby();
    int bad = 0;
    stby_sel = 1'b1; sleep_req = 1'b1;
    nx();
    sleep_req = 1'b0; stby_sel = 1'b0;
    check("R4", "mode", mode, 3);
    check("R4", "cpu/osc", {cpu_clk_en, osc_en}, 2'b00);
    check("R4", "mod_clk_en", mod_clk_en, 0);
    irq_req = 1'b1;
    nx();
    irq_req = 1'b0;
    check("R4", "irq ignored mode", mode, 3);
    check("R4", "irq ignored osc", osc_en, 0);
    wake_req = 1'b1;
    nx();
    wake_req = 1'b0;
    check("R5", "osc after wake", osc_en, 1);
    for (int i = 0; i < SETTLE_CYC; i++) begin
      if (cpu_clk_en !== 1'b0 || mode !== 3'd3) bad++;
      nx();
    end
    check("R5", "settle window errors", bad, 0);
    check("R5", "mode after settle", mode, 0);
    check("R5", "cpu after settle", cpu_clk_en, 1);
  endtask

  task automatic t_hw(bit from_ssb);
    int bad = 0;
    if (from_ssb) begin
      stby_sel = 1'b1; sleep_req = 1'b1; nx(); sleep_req = 1'b0; stby_sel = 1'b0;
    end else begin
      med_en = 1'b1; div_sel = 3'd0; nx();
    end
    hw_stby_n = 1'b0; irq_req = 1'b1; sleep_req = 1'b1; wake_req = 1'b1;
    nx();
    sleep_req = 1'b0; irq_req = 1'b0;
    check("R6", "mode", mode, 4);
    check("R6", "rst/osc/cpu", {periph_rst, osc_en, cpu_clk_en}, 3'b100);
    check("R6", "mod_clk_en", mod_clk_en, 0);
    repeat (3) nx();
    wake_req = 1'b0;
    check("R6", "held with wake", mode, 4);
    hw_stby_n = 1'b1; med_en = 1'b0;
    nx();
    check("R7", "osc on release", osc_en, 1);
    for (int i = 0; i < RST_CYC; i++) begin
      if (periph_rst !== 1'b1 || mode !== 3'd4 || cpu_clk_en !== 1'b0) bad++;
      nx();
    end
    check("R7", "recovery window errors", bad, 0);
    check("R7", "mode after recovery", mode, 0);
    check("R7", "rst after recovery", periph_rst, 0);
  endtask

  task automatic t_medium(logic [2:0] sel, int code);
    int bad = 0;
    int ratio = 2 << code;
    med_en = 1'b1; div_sel = sel;
    nx();
    check("R8", "mode", mode, 1);
    check("R8", "div_ratio", div_ratio, code);
    for (int k = 0; k < 3 * ratio; k++) begin
      if (cpu_clk_en !== (k % ratio == 0)) bad++;
      nx();
    end
    check("R8", $sformatf("pulse pattern ratio %0d", ratio), bad, 0);
    med_en = 1'b0;
    nx();
    check("R11", "mode after exit", mode, 0);
    check("R11", "cpu/ratio after exit", {cpu_clk_en, div_ratio}, 4'b1000);
  endtask

  task automatic t_ratio_change();
    int bad = 0;
    med_en = 1'b1; div_sel = 3'd1;
    nx();
    for (int k = 0; k <= 24; k++) begin
      if (cpu_clk_en !== (k == 0 || k == 4 || k == 20)) bad++;
      if (k >= 1 && k <= 3 && div_ratio !== 3'd1) bad++;
      if (k >= 4 && div_ratio !== 3'd3) bad++;
      if (k == 1) div_sel = 3'd3;
      nx();
    end
    check("R9", "mid-period change errors", bad, 0);
    med_en = 1'b0;
    nx();
  endtask

  task automatic t_mask();
    mod_stop = 8'h0F;
    nx();
    check("R10", "mask active", mod_clk_en, 8'hF0);
    check("R10", "cpu unaffected", cpu_clk_en, 1);
    mod_stop = 8'hFF; med_en = 1'b1; div_sel = 3'd0;
    nx();
    check("R10", "mask medium", mod_clk_en, 8'h00);
    check("R10", "cpu medium tick", cpu_clk_en, 1);
    med_en = 1'b0; mod_stop = 8'hA5;
    nx();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    nx();
    t_reset();
    t_sleep();
    t_swstby();
    t_hw(1'b0);
    t_hw(1'b1);
    t_medium(3'd0, 0);
    t_medium(3'd2, 2);
    t_medium(3'd4, 4);
    t_medium(3'd7, 4);
    t_ratio_change();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule